// File: doc/BRIEF.md
# Synchronous Receive Hunt Detector

This block watches a serial receive stream, one bit per strobe, and finds character alignment for three framed receive modes. In single-character sync mode it looks for one programmable 8-bit pattern. In double-character sync mode it looks for a 16-bit pattern made of two programmable characters. In bit-oriented framing mode it looks for the fixed flag pattern 0x7E. While it is searching, the hunt status output is high. On the strobe whose bit completes the pattern, hunt status drops and a one-cycle sync-found pulse is raised.

The receiver logic around the block can force a new search at any time. Four things start one: reset, an abort indication, the receiver enable going low, and a one-cycle hunt command. The hunt command does nothing in asynchronous mode. A separate pulse marks every change of the hunt status, in either direction, and feeds the external-status interrupt when that interrupt is enabled. The two sync characters are held in an internal pair of registers written through a small write port. Both are cleared by reset.

Top module: `sync_hunt_detector`

## Requirements
- R1: While reset is asserted and after its release, hunt_status is 1, sync_found and hunt_edge_irq are 0, both sync characters read as 0x00, and the 16-bit receive window holds all zeros.
- R2: The receive window moves only on a cycle with bit_en high. The new bit enters at the newest end, so a character sent least-significant bit first occupies the newest eight window bits with its bit 0 oldest. The comparison includes the bit arriving with that strobe.
- R3: With mode 2'b01 (single sync), a match occurs when the eight most recent bits equal sync character A.
- R4: With mode 2'b10 (double sync), a match occurs when the sixteen most recent bits equal character A received first, followed by character B received last.
- R5: With mode 2'b11 (flag framing), a match occurs when the eight most recent bits equal 0x7E, whatever the sync characters hold.
- R6: With mode 2'b00 (asynchronous), no match is ever reported, and a hunt command leaves hunt_status unchanged.
- R7: Each of these sets hunt_status to 1 at the next clock edge: abort_det high, rx_enable low, or hunt_cmd high in a framed mode.
- R8: If a hunt entry source is active in the same cycle as a matching strobe, the entry wins: hunt_status stays 1 and sync_found stays 0.
- R9: A match while hunting clears hunt_status and raises sync_found for exactly one cycle, at the edge that takes in the completing bit. While synchronized, later matches are ignored until a hunt entry occurs.
- R10: When ext_irq_en is 1, hunt_edge_irq pulses for one cycle at the edge on which hunt_status changes, both rising and falling. When ext_irq_en is 0, it stays 0.
- R11: A cycle with sync_wr high writes sync_wr_data to character A when sync_wr_sel is 0, and to character B when it is 1, leaving the other character unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bit_en | input | 1 | Receive bit strobe |
| rx_bit | input | 1 | Serial receive data |
| mode | input | 2 | 00 async, 01 single sync, 10 double sync, 11 flag framing |
| sync_wr | input | 1 | Sync character write strobe |
| sync_wr_sel | input | 1 | 0 selects character A, 1 selects character B |
| sync_wr_data | input | 8 | Sync character write data |
| hunt_cmd | input | 1 | One-cycle command to restart the search |
| rx_enable | input | 1 | Receiver enable; low forces hunting |
| abort_det | input | 1 | Abort indication; forces hunting |
| ext_irq_en | input | 1 | Enables the hunt-change interrupt pulse |
| hunt_status | output | 1 | 1 while searching, 0 once synchronized |
| sync_found | output | 1 | One-cycle pulse when synchronization is achieved |
| hunt_edge_irq | output | 1 | One-cycle pulse on each change of hunt_status |

## Verification
The hardest situation to reach from the ports is a clean search whose first possible match depends only on the stream under test. Leftover window contents from earlier traffic could otherwise complete a pattern early. Each table vector therefore shifts a known 16-bit prefix in while rx_enable is low, which holds the block in hunt and fills the window, before the measured stream begins. The other hard case is a hunt command that lands on the very strobe that completes a pattern. A directed test places both in one cycle, then sends one more matching bit.

// File: rtl/sync_hunt_pkg.sv
package sync_hunt_pkg;

  typedef enum logic [1:0] {
    RXM_ASYNC  = 2'b00,
    RXM_MONO   = 2'b01,
    RXM_BISYNC = 2'b10,
    RXM_FLAG   = 2'b11
  } rx_mode_e;

endpackage

// File: rtl/sync_word_bank.sv
module sync_word_bank #(
  parameter int CHAR_W    = 8,
  parameter int NUM_WORDS = 2,
  localparam int SEL_W    = (NUM_WORDS > 1) ? $clog2(NUM_WORDS) : 1
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic                          wr_en,
  input  logic [SEL_W-1:0]              wr_sel,
  input  logic [CHAR_W-1:0]             wr_data,
  output logic [NUM_WORDS*CHAR_W-1:0]   words
);

  for (genvar g = 0; g < NUM_WORDS; g++) begin : g_word
    logic [CHAR_W-1:0] word_q;
    logic [CHAR_W-1:0] word_d;

    always_comb begin
      word_d = word_q;
      if (wr_en && (wr_sel == SEL_W'(g))) begin
        word_d = wr_data;
      end
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        word_q <= '0;
      end else begin
        word_q <= word_d;
      end
    end

    assign words[g*CHAR_W +: CHAR_W] = word_q;
  end

  AST_WORDS_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_en |=> $stable(words)); // R11

endmodule

// File: rtl/serial_window.sv
module serial_window #(
  parameter int WIN_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             bit_en,
  input  logic             rx_bit,
  output logic [WIN_W-1:0] win_q,
  output logic [WIN_W-1:0] win_next
);

  always_comb begin
    win_next = win_q;
    if (bit_en) begin
      win_next = {rx_bit, win_q[WIN_W-1:1]};
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      win_q <= '0;
    end else begin
      win_q <= win_next;
    end
  end

  AST_WIN_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    !bit_en |=> $stable(win_q)); // R2

endmodule

// File: rtl/pattern_matcher.sv
module pattern_matcher
  import sync_hunt_pkg::*;
#(
  parameter int              CHAR_W = 8,
  parameter logic [CHAR_W-1:0] FLAG_PAT = 8'h7E,
  localparam int             WIN_W  = 2 * CHAR_W
) (
  input  rx_mode_e          mode,
  input  logic [WIN_W-1:0]  window,
  input  logic [CHAR_W-1:0] char_a,
  input  logic [CHAR_W-1:0] char_b,
  output logic              match
);

  logic [CHAR_W-1:0] newest_char;

  assign newest_char = window[WIN_W-1 -: CHAR_W];

  always_comb begin
    unique case (mode)
      RXM_MONO:   match = (newest_char == char_a);
      RXM_BISYNC: match = (window == {char_b, char_a});
      RXM_FLAG:   match = (newest_char == FLAG_PAT);
      default:    match = 1'b0;
    endcase
  end

endmodule

// File: rtl/hunt_ctrl.sv
module hunt_ctrl
  import sync_hunt_pkg::*;
(
  input  logic     clk,
  input  logic     rst_n,
  input  rx_mode_e mode,
  input  logic     bit_en,
  input  logic     match,
  input  logic     hunt_cmd,
  input  logic     rx_enable,
  input  logic     abort_det,
  input  logic     ext_irq_en,
  output logic     hunt_status,
  output logic     sync_found,
  output logic     hunt_edge_irq
);

  logic hunt_q, hunt_d;
  logic found_q, found_d;
  logic irq_q, irq_d;
  logic enter;
  logic acquire;

  assign enter   = abort_det | ~rx_enable | (hunt_cmd & (mode != RXM_ASYNC));
  assign acquire = hunt_q & ~enter & bit_en & match;

  always_comb begin
    hunt_d = hunt_q;
    if (enter) begin
      hunt_d = 1'b1;
    end else if (acquire) begin
      hunt_d = 1'b0;
    end
    found_d = acquire;
    irq_d   = ext_irq_en & (hunt_d != hunt_q);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hunt_q  <= 1'b1;
      found_q <= 1'b0;
      irq_q   <= 1'b0;
    end else begin
      hunt_q  <= hunt_d;
      found_q <= found_d;
      irq_q   <= irq_d;
    end
  end

  assign hunt_status   = hunt_q;
  assign sync_found    = found_q;
  assign hunt_edge_irq = irq_q;

  AST_ENTRY_FORCES_HUNT: assert property (@(posedge clk) disable iff (!rst_n)
    (abort_det || !rx_enable) |=> hunt_status); // R7
  AST_ENTRY_BEATS_MATCH: assert property (@(posedge clk) disable iff (!rst_n)
    enter |=> (hunt_status && !sync_found)); // R8
  AST_FOUND_ON_FALL: assert property (@(posedge clk) disable iff (!rst_n)
    sync_found |-> (!hunt_status && $past(hunt_status))); // R9
  AST_SYNC_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    (!hunt_status && !enter) |=> (!hunt_status && !sync_found)); // R9
  AST_ASYNC_NO_SYNC: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == RXM_ASYNC) |=> !sync_found); // R6
  AST_IRQ_ON_CHANGE: assert property (@(posedge clk) disable iff (!rst_n)
    hunt_edge_irq |-> (hunt_status != $past(hunt_status))); // R10
  AST_IRQ_MASKED: assert property (@(posedge clk) disable iff (!rst_n)
    !ext_irq_en |=> !hunt_edge_irq); // R10

endmodule

// File: rtl/sync_hunt_detector.sv
module sync_hunt_detector
  import sync_hunt_pkg::*;
#(
  parameter int                CHAR_W   = 8,
  parameter logic [CHAR_W-1:0] FLAG_PAT = 8'h7E
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bit_en,
  input  logic              rx_bit,
  input  logic [1:0]        mode,
  input  logic              sync_wr,
  input  logic              sync_wr_sel,
  input  logic [CHAR_W-1:0] sync_wr_data,
  input  logic              hunt_cmd,
  input  logic              rx_enable,
  input  logic              abort_det,
  input  logic              ext_irq_en,
  output logic              hunt_status,
  output logic              sync_found,
  output logic              hunt_edge_irq
);

  localparam int NUM_WORDS = 2;
  localparam int WIN_W     = 2 * CHAR_W;

  rx_mode_e                  mode_e;
  logic [NUM_WORDS*CHAR_W-1:0] words;
  logic [WIN_W-1:0]          win_q;
  logic [WIN_W-1:0]          win_next;
  logic                      match;

  assign mode_e = rx_mode_e'(mode);

  sync_word_bank #(
    .CHAR_W    (CHAR_W),
    .NUM_WORDS (NUM_WORDS)
  ) u_words (
    .clk     (clk),
    .rst_n   (rst_n),
    .wr_en   (sync_wr),
    .wr_sel  (sync_wr_sel),
    .wr_data (sync_wr_data),
    .words   (words)
  );

  serial_window #(
    .WIN_W (WIN_W)
  ) u_window (
    .clk      (clk),
    .rst_n    (rst_n),
    .bit_en   (bit_en),
    .rx_bit   (rx_bit),
    .win_q    (win_q),
    .win_next (win_next)
  );

  pattern_matcher #(
    .CHAR_W   (CHAR_W),
    .FLAG_PAT (FLAG_PAT)
  ) u_match (
    .mode   (mode_e),
    .window (win_next),
    .char_a (words[0 +: CHAR_W]),
    .char_b (words[CHAR_W +: CHAR_W]),
    .match  (match)
  );

  hunt_ctrl u_ctrl (
    .clk           (clk),
    .rst_n         (rst_n),
    .mode          (mode_e),
    .bit_en        (bit_en),
    .match         (match),
    .hunt_cmd      (hunt_cmd),
    .rx_enable     (rx_enable),
    .abort_det     (abort_det),
    .ext_irq_en    (ext_irq_en),
    .hunt_status   (hunt_status),
    .sync_found    (sync_found),
    .hunt_edge_irq (hunt_edge_irq)
  );

  AST_RESET_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rst_n) |-> (hunt_status && !sync_found)); // R1

endmodule

// File: tb/sync_hunt_detector_bench.sv
module sync_hunt_detector_bench;

  logic       clk = 1'b0;
  logic       rst_n;
  logic       bit_en, rx_bit;
  logic [1:0] mode;
  logic       sync_wr, sync_wr_sel;
  logic [7:0] sync_wr_data;
  logic       hunt_cmd, rx_enable, abort_det, ext_irq_en;
  logic       hunt_status, sync_found, hunt_edge_irq;

  int n_tests = 0;
  int n_fail  = 0;
  bit done    = 1'b0;

  always #2.5 clk = ~clk;

  sync_hunt_detector u_sync_hunt_detector (
    .clk           (clk),
    .rst_n         (rst_n),
    .bit_en        (bit_en),
    .rx_bit        (rx_bit),
    .mode          (mode),
    .sync_wr       (sync_wr),
    .sync_wr_sel   (sync_wr_sel),
    .sync_wr_data  (sync_wr_data),
    .hunt_cmd      (hunt_cmd),
    .rx_enable     (rx_enable),
    .abort_det     (abort_det),
    .ext_irq_en    (ext_irq_en),
    .hunt_status   (hunt_status),
    .sync_found    (sync_found),
    .hunt_edge_irq (hunt_edge_irq)
  );

  // fields: mode(2) charA(8) charB(8) prefix(16) stream(32) first match index(8, 255 = none)
  localparam int NVEC = 8;
  localparam logic [73:0] VECS [NVEC] = '{
    {2'b01, 8'h16, 8'h00, 16'h0000, 32'h0000_1600, 8'd15},  // R3 single sync
    {2'b01, 8'hA5, 8'h00, 16'h0000, 32'h0000_0000, 8'd255}, // R3 no match
    {2'b10, 8'h96, 8'h69, 16'h0000, 32'h0000_6996, 8'd15},  // R4 double sync
    {2'b10, 8'h96, 8'h69, 16'h0000, 32'h6996_6896, 8'd31},  // R4 bad second char first
    {2'b11, 8'h00, 8'h00, 16'h0000, 32'h0000_7E00, 8'd15},  // R5 flag
    {2'b11, 8'h00, 8'h00, 16'h0000, 32'h0000_00FE, 8'd255}, // R5 seven ones, no flag
    {2'b00, 8'h16, 8'h00, 16'h0000, 32'h0000_1600, 8'd255}, // R6 async never syncs
    {2'b01, 8'hFF, 8'h00, 16'h0000, 32'hFFFF_FFFF, 8'd7}    // R9 repeated matches
  };

  task automatic tick();
    @(posedge clk);
    #1;
  endtask

  task automatic check(input bit ok, input string req, input int act, input int exp);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic write_char(input bit sel, input logic [7:0] val);
    sync_wr      = 1'b1;
    sync_wr_sel  = sel;
    sync_wr_data = val;
    tick();
    sync_wr      = 1'b0;
  endtask

  task automatic send_bit(input logic b);
    bit_en = 1'b1;
    rx_bit = b;
    tick();
    bit_en = 1'b0;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog: actual %0d expected %0d", 0, 1);
      $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

  initial begin
    logic [73:0] vec;
    logic [15:0] pre;
    logic [31:0] stream;
    int first, pulses, irqs, expi;

    rst_n = 1'b0; bit_en = 1'b0; rx_bit = 1'b0; mode = 2'b01;
    sync_wr = 1'b0; sync_wr_sel = 1'b0; sync_wr_data = '0;
    hunt_cmd = 1'b0; rx_enable = 1'b1; abort_det = 1'b0; ext_irq_en = 1'b1;
    repeat (3) tick();

    // R1 reset state
    check(hunt_status == 1'b1, "R1 hunt in reset", hunt_status, 1);
    check(sync_found == 1'b0 && hunt_edge_irq == 1'b0, "R1 pulses low in reset",
          {sync_found, hunt_edge_irq}, 0);
    rst_n = 1'b1;
    tick();
    check(hunt_status == 1'b1, "R1 hunt after release", hunt_status, 1);

    // R1: character A and window are zero, so one zero bit completes a match
    send_bit(1'b0);
    check(sync_found == 1'b1 && hunt_status == 1'b0, "R1 zero char matches zero window",
          {sync_found, hunt_status}, 2);
    check(hunt_edge_irq == 1'b1, "R10 falling edge pulse", hunt_edge_irq, 1);

    // R9 further matches ignored while synchronized
    pulses = 0;
    for (int i = 0; i < 3; i++) begin
      send_bit(1'b0);
      if (sync_found || hunt_edge_irq) pulses++;
    end
    check(pulses == 0 && hunt_status == 1'b0, "R9 matches ignored while synced", pulses, 0);

    // R6 hunt command ignored in async mode
    mode = 2'b00; hunt_cmd = 1'b1;
    tick();
    hunt_cmd = 1'b0;
    check(hunt_status == 1'b0 && hunt_edge_irq == 1'b0, "R6 hunt cmd ignored in async",
          hunt_status, 0);

    // R7 hunt command in single sync mode, R10 rising edge pulse
    mode = 2'b01; hunt_cmd = 1'b1;
    tick();
    hunt_cmd = 1'b0;
    check(hunt_status == 1'b1, "R7 hunt cmd enters hunt", hunt_status, 1);
    check(hunt_edge_irq == 1'b1, "R10 rising edge pulse", hunt_edge_irq, 1);
    tick();
    check(hunt_edge_irq == 1'b0, "R10 pulse lasts one cycle", hunt_edge_irq, 0);

    // R2 no strobe, no acquisition even though window already matches
    rx_bit = 1'b0;
    tick();
    check(hunt_status == 1'b1 && sync_found == 1'b0, "R2 no strobe no match", hunt_status, 1);

    // R8 entry wins over a matching strobe
    hunt_cmd = 1'b1;
    send_bit(1'b0);
    hunt_cmd = 1'b0;
    check(hunt_status == 1'b1 && sync_found == 1'b0, "R8 entry beats match",
          {hunt_status, sync_found}, 2);
    send_bit(1'b0);
    check(sync_found == 1'b1, "R8 match after entry released", sync_found, 1);
    tick();
    check(sync_found == 1'b0, "R9 sync_found one cycle", sync_found, 0);

    // R7 abort re-enters hunt
    abort_det = 1'b1;
    tick();
    abort_det = 1'b0;
    check(hunt_status == 1'b1, "R7 abort enters hunt", hunt_status, 1);

    // R10 masked interrupt on both edges
    ext_irq_en = 1'b0;
    send_bit(1'b0);
    check(sync_found == 1'b1 && hunt_edge_irq == 1'b0, "R10 masked on fall", hunt_edge_irq, 0);
    abort_det = 1'b1;
    tick();
    abort_det = 1'b0;
    check(hunt_status == 1'b1 && hunt_edge_irq == 1'b0, "R10 masked on rise", hunt_edge_irq, 0);
    ext_irq_en = 1'b1;

    // R11 writing B leaves A intact
    write_char(1'b0, 8'h3C);
    write_char(1'b1, 8'hFF);
    rx_enable = 1'b0;
    for (int i = 0; i < 16; i++) send_bit(1'b0);
    rx_enable = 1'b1;
    first = 255;
    for (int i = 0; i < 8; i++) begin
      send_bit(i >= 2 && i <= 5);
      if (sync_found && first == 255) first = i;
    end
    check(first == 7, "R11 char A kept after B write", first, 7);

    // table of vectors
    for (int v = 0; v < NVEC; v++) begin
      vec    = VECS[v];
      mode   = vec[73:72];
      write_char(1'b0, vec[71:64]);
      write_char(1'b1, vec[63:56]);
      pre    = vec[55:40];
      stream = vec[39:8];
      expi   = int'(vec[7:0]);
      rx_enable = 1'b0;
      for (int i = 0; i < 16; i++) send_bit(pre[i]);
      check(hunt_status == 1'b1, "R7 disabled receiver hunts", hunt_status, 1);
      rx_enable = 1'b1;
      first = 255; pulses = 0; irqs = 0;
      for (int i = 0; i < 32; i++) begin
        send_bit(stream[i]);
        if (sync_found) begin
          if (first == 255) first = i;
          pulses++;
        end
        if (hunt_edge_irq) irqs++;
      end
      check(first == expi, "R2 R3 R4 R5 R6 first match index", first, expi);
      check(pulses == ((expi == 255) ? 0 : 1), "R9 single sync pulse", pulses,
            (expi == 255) ? 0 : 1);
      check(irqs == pulses, "R10 irq per hunt change", irqs, pulses);
      check(hunt_status == (expi == 255), "R9 hunt at end of stream", hunt_status,
            (expi == 255) ? 1 : 0);
    end

    done = 1'b1;
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

endmodule